// File: doc/BRIEF.md
# Phase-One SPI Master Transfer Engine

This block is a full-duplex SPI master for the two modes that launch data on the first clock edge of a word and sample on the second (clock phase one). The controller accepts a parallel word over a valid/ready port. It shifts it out MSB first on `mosi` and shifts an equally long word in from `miso`. The received word is returned right-aligned together with a one-cycle valid pulse. The word length, the serial clock polarity and the serial clock rate come from configuration inputs. The serial clock is derived from the system clock by a divider.

The active-low select `cs_n` is asserted a programmable lead interval before the first serial clock edge. It is released a programmable lag interval after the last edge. With the hold option set, the select stays asserted between words and the next word begins without a lead interval. In three-pin mode the select output is driven low at all times and the clock and data waveforms do not change.

Back-pressure rules: `tx_ready` is high only while the engine is idle or waiting between held words. A word is taken on a cycle where `tx_valid` and `tx_ready` are both high, and `tx_valid` while `tx_ready` is low has no effect. The receive side has no ready. `rx_valid` is a single-cycle pulse, and the consumer must take `rx_data` in that cycle. Configuration inputs must stay stable while `busy` is high.

Top module: `spi1m_master`

## Requirements
- R1: A word is accepted only when `tx_valid` and `tx_ready` are both high. `tx_ready` is low from acceptance until the engine is idle again or waiting in hold. `tx_valid` presented while `tx_ready` is low starts no transfer.
- R2: While idle, `sclk` rests at `cfg_cpol` (0 gives a low idle level, 1 gives a high idle level). The first edge of every word moves `sclk` away from that level.
- R3: The effective length N is `cfg_len` clamped to the range 4..32. A word of N bits produces exactly 2N `sclk` edges.
- R4: `mosi` changes only on odd-numbered edges (1, 3, 5 and so on). The bits of `tx_data[N-1:0]` go out MSB first, and bit N-1 appears on edge 1, not earlier.
- R5: `miso` is sampled on even-numbered edges, MSB first. `rx_data` holds the N bits right-aligned, with the upper bits zero.
- R6: `rx_valid` is high for exactly one cycle. That cycle is the one in which the last (2N-th) edge returns `sclk` to its idle level.
- R7: Consecutive `sclk` edges within a word are (`cfg_div`+1) system clocks apart.
- R8: Starting from idle, `cs_n` falls in the cycle after acceptance. The first edge follows L×(`cfg_div`+1) cycles later, where L is `cfg_lead` and a value of 0 is treated as 1.
- R9: Without hold, `cs_n` rises G×(`cfg_div`+1) cycles after the last edge, where G is `cfg_lag` and a value of 0 is treated as 1. `busy` falls in the same cycle.
- R10: With `cfg_hold` set, `cs_n` stays low between words. A word accepted while waiting has its first edge (`cfg_div`+1) cycles after acceptance, with no lead interval. Clearing `cfg_hold` while waiting runs the lag interval and then releases `cs_n`.
- R11: With `cfg_three_pin` set, `cs_n` is 0 at all times and transfers proceed unchanged.
- R12: `mosi` holds the last bit it drove, which is the LSB of the previous word, until edge 1 of the next word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous-free active-low reset, sampled on `clk` |
| cfg_cpol | input | 1 | Serial clock idle level |
| cfg_len | input | 6 | Word length in bits, clamped to 4..32 |
| cfg_div | input | 8 | Half-period of `sclk` minus one, in system clocks |
| cfg_lead | input | 4 | Select-to-first-edge delay in half-periods (0 means 1) |
| cfg_lag | input | 4 | Last-edge-to-release delay in half-periods (0 means 1) |
| cfg_hold | input | 1 | Keep select asserted between words |
| cfg_three_pin | input | 1 | Force `cs_n` low permanently |
| tx_valid | input | 1 | Transmit word offered |
| tx_ready | output | 1 | Engine can take a word |
| tx_data | input | 32 | Transmit word, right-aligned |
| rx_valid | output | 1 | One-cycle pulse, received word valid |
| rx_data | output | 32 | Received word, right-aligned |
| busy | output | 1 | Transfer or select sequence in progress |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs_n | output | 1 | Active-low select |

## Verification
The bench covers both polarities, the shortest and longest lengths, out-of-range lengths that must clamp, divider zero, and zero lead and lag values that must behave as one. Each of these has a distinct failure: an off-by-one edge count shifts the received word by a bit, a missing clamp loses or invents bits, and treating zero as zero collapses the select timing. Back-to-back held words are driven to confirm that the select never rises between them and that no lead gap is inserted. Offers made while the engine is busy are driven to confirm that a design which accepts them would emit an extra word. The bench also checks that `mosi` keeps the previous LSB up to the first edge, which catches a design that drives the MSB early at select assertion.

// File: rtl/spi1m_pkg.sv
package spi1m_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_LEAD  = 3'd1,
    ST_SHIFT = 3'd2,
    ST_HOLD  = 3'd3,
    ST_LAG   = 3'd4
  } phase_e;

endpackage

// File: rtl/spi1m_tick.sv
module spi1m_tick #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);

  logic [DIV_W-1:0] cnt;

  // Half-period timer: restarts from zero whenever the sequencer pauses.
  always_ff @(posedge clk) begin
    if (!rst_n)          cnt <= '0;
    else if (!run)       cnt <= '0;
    else if (cnt == div) cnt <= '0;
    else                 cnt <= cnt + DIV_W'(1);
  end

  assign tick = run && (cnt == div);

endmodule

// File: rtl/spi1m_shift.sv
module spi1m_shift #(
  parameter int MAX_BITS = 32,
  parameter int LEN_W    = 6
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                load,
  input  logic [MAX_BITS-1:0] tx_word,
  input  logic [LEN_W-1:0]    nbits,
  input  logic                edge_go,
  input  logic                miso,
  output logic                mosi,
  output logic                last,
  output logic                rx_valid,
  output logic [MAX_BITS-1:0] rx_word
);

  localparam int EC_W = LEN_W + 1;

  logic [MAX_BITS-1:0] tx_sr;
  logic [MAX_BITS-1:0] rx_sr;
  logic [EC_W-1:0]     ecnt;
  logic [EC_W-1:0]     last_idx;
  logic [LEN_W-1:0]    pad;
  logic                odd_next;

  assign pad      = LEN_W'(MAX_BITS) - nbits;
  assign last_idx = {nbits, 1'b0} - EC_W'(1);
  assign last     = (ecnt == last_idx);
  assign odd_next = ~ecnt[0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_sr    <= '0;
      rx_sr    <= '0;
      ecnt     <= '0;
      mosi     <= 1'b0;
      rx_valid <= 1'b0;
      rx_word  <= '0;
    end else begin
      rx_valid <= 1'b0;
      if (load) begin
        // MSB of the programmed word is moved to the top of the register.
        tx_sr <= tx_word << pad;
        rx_sr <= '0;
        ecnt  <= '0;
      end else if (edge_go) begin
        ecnt <= ecnt + EC_W'(1);
        if (odd_next) begin
          mosi  <= tx_sr[MAX_BITS-1];
          tx_sr <= {tx_sr[MAX_BITS-2:0], 1'b0};
        end else begin
          rx_sr <= {rx_sr[MAX_BITS-2:0], miso};
          if (last) begin
            rx_word  <= {rx_sr[MAX_BITS-2:0], miso};
            rx_valid <= 1'b1;
          end
        end
      end
    end
  end

endmodule

// File: rtl/spi1m_ctrl.sv
module spi1m_ctrl
  import spi1m_pkg::*;
#(
  parameter int DLY_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tx_valid,
  input  logic             hold,
  input  logic [DLY_W-1:0] lead,
  input  logic [DLY_W-1:0] lag,
  input  logic             tick,
  input  logic             last,
  output logic             tx_ready,
  output logic             load,
  output logic             edge_go,
  output logic             run,
  output logic             busy,
  output logic             in_idle
);

  phase_e           st;
  logic [DLY_W-1:0] dly;
  logic [DLY_W-1:0] lead_eff;
  logic [DLY_W-1:0] lag_eff;
  logic             dly_end;

  assign lead_eff = (lead == '0) ? DLY_W'(1) : lead;
  assign lag_eff  = (lag  == '0) ? DLY_W'(1) : lag;
  assign dly_end  = (dly == DLY_W'(1));

  assign tx_ready = (st == ST_IDLE) || (st == ST_HOLD);
  assign load     = tx_valid && tx_ready;
  assign busy     = (st != ST_IDLE);
  assign in_idle  = (st == ST_IDLE);
  assign run      = (st == ST_LEAD) || (st == ST_SHIFT) || (st == ST_LAG);
  assign edge_go  = tick && ((st == ST_SHIFT) || ((st == ST_LEAD) && dly_end));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st  <= ST_IDLE;
      dly <= '0;
    end else begin
      unique case (st)
        ST_IDLE: if (tx_valid) begin
          st  <= ST_LEAD;
          dly <= lead_eff;
        end
        ST_LEAD: if (tick) begin
          if (dly_end) st <= ST_SHIFT;
          else         dly <= dly - DLY_W'(1);
        end
        ST_SHIFT: if (edge_go && last) begin
          if (hold) st <= ST_HOLD;
          else begin
            st  <= ST_LAG;
            dly <= lag_eff;
          end
        end
        ST_HOLD: begin
          if (tx_valid) st <= ST_SHIFT;
          else if (!hold) begin
            st  <= ST_LAG;
            dly <= lag_eff;
          end
        end
        ST_LAG: if (tick) begin
          if (dly_end) st <= ST_IDLE;
          else         dly <= dly - DLY_W'(1);
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/spi1m_master.sv
module spi1m_master #(
  parameter int MAX_BITS = 32,
  parameter int MIN_BITS = 4,
  parameter int DIV_W    = 8,
  parameter int DLY_W    = 4,
  localparam int LEN_W   = $clog2(MAX_BITS + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cfg_cpol,
  input  logic [LEN_W-1:0]    cfg_len,
  input  logic [DIV_W-1:0]    cfg_div,
  input  logic [DLY_W-1:0]    cfg_lead,
  input  logic [DLY_W-1:0]    cfg_lag,
  input  logic                cfg_hold,
  input  logic                cfg_three_pin,
  input  logic                tx_valid,
  output logic                tx_ready,
  input  logic [MAX_BITS-1:0] tx_data,
  output logic                rx_valid,
  output logic [MAX_BITS-1:0] rx_data,
  output logic                busy,
  output logic                sclk,
  output logic                mosi,
  input  logic                miso,
  output logic                cs_n
);

  logic [LEN_W-1:0] nbits;
  logic tick, run, load, edge_go, last, in_idle, sclk_q;

  always_comb begin
    if (cfg_len < LEN_W'(MIN_BITS))      nbits = LEN_W'(MIN_BITS);
    else if (cfg_len > LEN_W'(MAX_BITS)) nbits = LEN_W'(MAX_BITS);
    else                                 nbits = cfg_len;
  end

  spi1m_tick #(.DIV_W(DIV_W)) u_tick (
    .clk(clk), .rst_n(rst_n), .run(run), .div(cfg_div), .tick(tick)
  );

  spi1m_ctrl #(.DLY_W(DLY_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .tx_valid(tx_valid), .hold(cfg_hold),
    .lead(cfg_lead), .lag(cfg_lag), .tick(tick), .last(last),
    .tx_ready(tx_ready), .load(load), .edge_go(edge_go), .run(run),
    .busy(busy), .in_idle(in_idle)
  );

  spi1m_shift #(.MAX_BITS(MAX_BITS), .LEN_W(LEN_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .load(load), .tx_word(tx_data), .nbits(nbits),
    .edge_go(edge_go), .miso(miso), .mosi(mosi), .last(last),
    .rx_valid(rx_valid), .rx_word(rx_data)
  );

  // Serial clock: parks at the polarity level when idle, toggles per edge.
  always_ff @(posedge clk) begin
    if (!rst_n)       sclk_q <= 1'b0;
    else if (in_idle) sclk_q <= cfg_cpol;
    else if (edge_go) sclk_q <= ~sclk_q;
  end

  assign sclk = sclk_q;
  assign cs_n = cfg_three_pin ? 1'b0 : ~busy;

endmodule

// File: rtl/spi1m_chk.sv
module spi1m_chk (
  input logic clk,
  input logic rst_n,
  input logic cfg_cpol,
  input logic tx_valid,
  input logic tx_ready,
  input logic busy,
  input logic sclk,
  input logic mosi,
  input logic cs_n,
  input logic rx_valid
);

  // R1
  accept_goes_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && tx_ready && !busy) |=> (busy && !tx_ready));

  // R2
  idle_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !busy && !$past(busy) && $stable(cfg_cpol)) |-> (sclk == cfg_cpol));

  // R4
  mosi_on_odd_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(mosi) |-> (!$stable(sclk) && (sclk != cfg_cpol)));

  // R6
  done_on_last_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> (!$stable(sclk) && (sclk == cfg_cpol)));

  // R6
  done_single_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);

  // R8
  select_before_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cs_n) |-> $stable(sclk));

  // R9
  release_when_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cs_n) |-> !busy);

endmodule

bind spi1m_master spi1m_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_cpol(cfg_cpol), .tx_valid(tx_valid),
  .tx_ready(tx_ready), .busy(busy), .sclk(sclk), .mosi(mosi),
  .cs_n(cs_n), .rx_valid(rx_valid)
);

// File: tb/tb_spi1m_master.sv
`timescale 1ns/1ps
module tb_spi1m_master;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_cpol = 1'b0;
  logic [5:0]  cfg_len = 6'd8;
  logic [7:0]  cfg_div = 8'd1;
  logic [3:0]  cfg_lead = 4'd1;
  logic [3:0]  cfg_lag = 4'd1;
  logic        cfg_hold = 1'b0;
  logic        cfg_three_pin = 1'b0;
  logic        tx_valid = 1'b0;
  logic        tx_ready;
  logic [31:0] tx_data = '0;
  logic        rx_valid;
  logic [31:0] rx_data;
  logic        busy, sclk, mosi, cs_n;
  logic        miso = 1'b0;

  always #2 clk = ~clk;

  spi1m_master dut (
    .clk(clk), .rst_n(rst_n), .cfg_cpol(cfg_cpol), .cfg_len(cfg_len),
    .cfg_div(cfg_div), .cfg_lead(cfg_lead), .cfg_lag(cfg_lag),
    .cfg_hold(cfg_hold), .cfg_three_pin(cfg_three_pin),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
    .rx_valid(rx_valid), .rx_data(rx_data), .busy(busy), .sclk(sclk),
    .mosi(mosi), .miso(miso), .cs_n(cs_n)
  );

  int checks = 0, errors = 0;
  bit finished = 0;
  int cur_n = 8, hp = 8, lead_eff = 1, lag_eff = 1;
  logic [31:0] exp_rx[$], exp_mosi[$], slave_pat[$];
  int ek = 0, etot = 0, rx_cnt = 0, cs_rise = 0, cs_chg = 0;
  logic [31:0] spat = '0, cap = '0;
  time t_acc = 0, t_prev = 0, t_last = 0, t_csf = 0;
  bit idle_start = 0, lag_en = 1, prev_rxv = 0, last_lsb = 0;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] mask(input int n);
    return (n >= 32) ? 32'hFFFF_FFFF : ((32'h1 << n) - 32'h1);
  endfunction

  task automatic set_cfg(input bit pol, input int len, input int dv, input int ld, input int lg);
    @(negedge clk);
    cfg_cpol = pol; cfg_len = 6'(len); cfg_div = 8'(dv);
    cfg_lead = 4'(ld); cfg_lag = 4'(lg);
    cur_n = (len < 4) ? 4 : ((len > 32) ? 32 : len);
    hp = (dv + 1) * 4;
    lead_eff = (ld == 0) ? 1 : ld;
    lag_eff = (lg == 0) ? 1 : lg;
    repeat (2) @(negedge clk);
  endtask

  // Driver: pushes expectations, offers the word, waits until its first edge.
  task automatic send(input logic [31:0] tx, input logic [31:0] slv);
    exp_mosi.push_back(tx & mask(cur_n));
    exp_rx.push_back(slv & mask(cur_n));
    slave_pat.push_back(slv);
    idle_start = !busy;
    tx_data = tx;
    tx_valid = 1'b1;
    while (!tx_ready) @(negedge clk);
    @(posedge clk);
    t_acc = $time;
    @(negedge clk);
    tx_valid = 1'b0;
    // R12: previous LSB still on mosi before edge 1
    chk(mosi == last_lsb, "R12 mosi before first edge", mosi, last_lsb);
    while (ek == 0) @(negedge clk);
    last_lsb = tx[0];
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (busy) @(negedge clk);
  endtask

  // Slave model and edge timing
  always @(sclk) begin
    if (rst_n && busy) begin
      etot++;
      ek++;
      if (ek == 1) begin
        spat = (slave_pat.size() > 0) ? slave_pat.pop_front() : 32'h0;
        chk(sclk != cfg_cpol, "R2 first edge leaves idle", sclk, !cfg_cpol);
        if (idle_start) begin
          chk(($time - t_acc) == lead_eff * hp, "R8 lead interval", $time - t_acc, lead_eff * hp);
          if (!cfg_three_pin) chk(t_csf == t_acc, "R8 select falls at accept", t_csf, t_acc);
        end else begin
          chk(($time - t_acc) == hp, "R10 held word start", $time - t_acc, hp);
        end
      end else begin
        chk(($time - t_prev) == hp, "R7 half period", $time - t_prev, hp);
      end
      t_prev = $time;
      if (ek % 2 == 1) begin
        miso = spat[cur_n - 1 - (ek - 1) / 2];
      end else begin
        cap = {cap[30:0], mosi};
        if (ek == 2 * cur_n) begin
          logic [31:0] e;
          e = (exp_mosi.size() > 0) ? exp_mosi.pop_front() : 32'h0;
          chk((cap & mask(cur_n)) == e, "R4 mosi word", cap & mask(cur_n), e);
          t_last = $time;
          ek = 0;
          cap = '0;
        end
      end
    end
  end

  always @(negedge cs_n) t_csf = $time;
  always @(cs_n) if (rst_n) cs_chg++;
  always @(posedge cs_n) begin
    if (rst_n) begin
      cs_rise++;
      if (lag_en) chk(($time - t_last) == lag_eff * hp, "R9 lag interval", $time - t_last, lag_eff * hp);
    end
  end

  // Monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n) begin
      if (rx_valid) begin
        logic [31:0] e;
        chk(prev_rxv == 1'b0, "R6 pulse width", prev_rxv, 0);
        chk(etot == 2 * cur_n, "R3 edge count", etot, 2 * cur_n);
        etot = 0;
        e = (exp_rx.size() > 0) ? exp_rx.pop_front() : 32'hDEAD_BEEF;
        chk(rx_data == e, "R5 rx word", rx_data, e);
        rx_cnt++;
      end
      prev_rxv = rx_valid;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; errors++;
      $display("FAIL watchdog: got %0d expected %0d", 0, 1);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int base;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(cs_n == 1'b1, "R9 reset cs_n", cs_n, 1);
    chk(sclk == 1'b0, "R2 reset sclk", sclk, 0);
    chk(tx_ready == 1'b1, "R1 reset ready", tx_ready, 1);
    chk(busy == 1'b0, "R1 reset busy", busy, 0);
    chk(rx_valid == 1'b0, "R6 reset rx_valid", rx_valid, 0);

    // Polarity 0, 8 bits
    set_cfg(0, 8, 1, 2, 3);
    send(32'hA5, 32'h3C); wait_idle();
    chk(mosi == last_lsb, "R12 mosi holds in idle", mosi, last_lsb);
    send(32'h5A, 32'hC3); wait_idle();

    // Polarity 1, 13 bits, divider 0, zero lead/lag
    set_cfg(1, 13, 0, 0, 0);
    chk(sclk == 1'b1, "R2 idle high", sclk, 1);
    send(32'h1ABC, 32'h0F0F); wait_idle();
    send(32'hFFFF_0555, 32'hFFFF_1AAA); wait_idle();

    // 32 bits
    set_cfg(0, 32, 2, 1, 1);
    chk(sclk == 1'b0, "R2 idle low", sclk, 0);
    send(32'hDEAD_BEEF, 32'h8000_0001); wait_idle();

    // Clamping
    set_cfg(1, 2, 1, 1, 2);
    send(32'hFFFF_FFF9, 32'hFFFF_FFF6); wait_idle();
    set_cfg(0, 40, 0, 3, 1);
    send(32'h1234_5678, 32'hCAFE_F00D); wait_idle();

    // R1: offers while busy are ignored
    set_cfg(0, 8, 3, 1, 1);
    base = rx_cnt;
    send(32'h96, 32'h69);
    for (int i = 0; i < 6; i++) begin
      tx_valid = 1'b1; tx_data = 32'hFF;
      chk(tx_ready == 1'b0, "R1 not ready while busy", tx_ready, 0);
      @(negedge clk);
    end
    tx_valid = 1'b0;
    wait_idle();
    repeat (20) @(negedge clk);
    chk(rx_cnt == base + 1, "R1 busy offer ignored", rx_cnt, base + 1);
    chk(busy == 1'b0, "R1 no extra transfer", busy, 0);

    // R10: held back-to-back words
    set_cfg(1, 6, 1, 2, 2);
    cfg_hold = 1'b1; lag_en = 0;
    base = rx_cnt;
    send(32'h2D, 32'h13);
    send(32'h11, 32'h3E);
    send(32'h3F, 32'h00);
    while (rx_cnt < base + 3) @(negedge clk);
    repeat (3) @(negedge clk);
    chk(cs_n == 1'b0, "R10 select held", cs_n, 0);
    chk(tx_ready == 1'b1, "R10 ready in hold", tx_ready, 1);
    begin
      int r0;
      r0 = cs_rise;
      cfg_hold = 1'b0;
      wait_idle();
      chk(cs_rise == r0 + 1, "R10 single release", cs_rise, r0 + 1);
    end
    chk(cs_n == 1'b1, "R10 released", cs_n, 1);

    // R11: three-pin mode
    set_cfg(0, 8, 0, 1, 1);
    cfg_three_pin = 1'b1;
    @(negedge clk);
    begin
      int c0;
      c0 = cs_chg;
      chk(cs_n == 1'b0, "R11 select low", cs_n, 0);
      send(32'hC7, 32'h81); wait_idle();
      send(32'h18, 32'h7E); wait_idle();
      chk(cs_chg == c0, "R11 select never moves", cs_chg, c0);
    end
    cfg_three_pin = 1'b0;
    repeat (4) @(negedge clk);
    lag_en = 1;
    chk(exp_rx.size() == 0, "R5 all words returned", exp_rx.size(), 0);

    if (!finished) begin
      finished = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule